// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This block evaluates expressions on a small pushdown operand stack held in on-chip registers. It takes a stream of already decoded operations over a valid/ready handshake. Each operation names its operands only implicitly: the top one or two stack entries. Only the push and pop operations touch data memory, through a plain synchronous read/write port. Binary operations consume the two top entries and leave one result. Unary operations rewrite the top entry in place.

A typical use is straight-line expression code. For example, an assignment of a sum is issued as push of the first source, push of the second source, add, then pop to the destination address. Status outputs report an empty stack and a full stack. A sticky error flag reports any operation that the current depth cannot support. The stack depth is a parameter; the words are 32 bits wide and memory addresses are 16 bits wide.

Top module: `stk_exec_core`

## Requirements
- R1: After reset the stack is empty: `stk_empty`=1, `stk_full`=0, `stk_err`=0, `op_ready`=1, and neither memory strobe is active.
- R2: A push (`op_cls`=0) that is accepted on a stack that is not full drives `mem_rd_en`=1 with `mem_addr`=`op_addr` in the accept cycle. It holds `op_ready` low for the next cycle. The word returned on `mem_rdata` in that cycle becomes the new top entry, and the depth grows by one.
- R3: An accepted pop (`op_cls`=1) on a stack that is not empty drives `mem_wr_en`=1, `mem_addr`=`op_addr` and `mem_wdata`=top entry in the accept cycle. It removes the top entry.
- R4: A binary operation (`op_cls`=2) takes the entry below the top as operand A and the top entry as operand B. It removes both and pushes one result, so the depth drops by one. `op_func` selects the result: 0 A+B, 1 A-B, 2 A and B, 3 A or B, 4 not(A or B), 5 A xor B, 6 signed A<B (gives 1 or 0), 7 unsigned A<B (gives 1 or 0).
- R5: A unary operation (`op_cls`=3) overwrites the top entry and leaves the depth unchanged. `op_func` selects the result: 0 two's-complement negate, 1 bitwise invert, 2 shift left by one, 3 logical shift right by one, 4 to 7 leave the value unchanged.
- R6: Entries below the top two are never read or altered by any operation, so successive pops return words in reverse order of their pushes.
- R7: `stk_empty` is 1 exactly when the depth is 0, and `stk_full` is 1 exactly when the depth equals DEPTH.
- R8: A push on a full stack, a pop or unary operation on an empty stack, and a binary operation with fewer than two entries each set `stk_err`. Such an operation leaves the stack unchanged, strobes no memory, and completes in one cycle.
- R9: `stk_err` stays set until reset, and later legal operations still execute while it is set.
- R10: Pop, binary and unary operations complete in the accept cycle with `op_ready` high on the next cycle. Only the legal push adds a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered |
| op_ready | output | 1 | The core accepts an operation this cycle |
| op_cls | input | 2 | Operation class: 0 push, 1 pop, 2 binary, 3 unary |
| op_func | input | 3 | Function select for binary and unary classes |
| op_addr | input | 16 | Memory address for push and pop |
| mem_rd_en | output | 1 | Memory read strobe; data is due on the next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the strobe |
| stk_empty | output | 1 | Stack depth is zero |
| stk_full | output | 1 | Stack depth equals DEPTH |
| stk_err | output | 1 | Sticky error flag |

## Verification
On every cycle the assertions check the depth changes that each legal operation class must cause, and that a rejected operation freezes the depth and strobes no memory. They also check that the error flag never clears without reset, that the depth stays within bounds, that the two flags are never set together, and that the push wait cycle is held. The arithmetic results, the operand order of the binary operations, the reverse order in which pops return words, and the correct data landing from memory can only be shown by the bench. It drives operation sequences against a reference stack model and watches the words that pops write to memory.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    CLS_PUSH = 2'd0,
    CLS_POP  = 2'd1,
    CLS_BIN  = 2'd2,
    CLS_UNA  = 2'd3
  } op_cls_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_FILL = 1'b1
  } core_state_e;

  // binary function codes (A = entry below top, B = top)
  localparam logic [2:0] BF_ADD  = 3'd0;
  localparam logic [2:0] BF_SUB  = 3'd1;
  localparam logic [2:0] BF_AND  = 3'd2;
  localparam logic [2:0] BF_OR   = 3'd3;
  localparam logic [2:0] BF_NOR  = 3'd4;
  localparam logic [2:0] BF_XOR  = 3'd5;
  localparam logic [2:0] BF_SLT  = 3'd6;
  localparam logic [2:0] BF_SLTU = 3'd7;

  // unary function codes
  localparam logic [2:0] UF_NEG = 3'd0;
  localparam logic [2:0] UF_NOT = 3'd1;
  localparam logic [2:0] UF_SHL = 3'd2;
  localparam logic [2:0] UF_SHR = 3'd3;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         is_bin,
  input  logic [2:0]   func,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [W-1:0] bin_y;
  logic [W-1:0] una_y;

  always_comb begin
    unique case (func)
      BF_ADD:  bin_y = a + b;
      BF_SUB:  bin_y = a - b;
      BF_AND:  bin_y = a & b;
      BF_OR:   bin_y = a | b;
      BF_NOR:  bin_y = ~(a | b);
      BF_XOR:  bin_y = a ^ b;
      BF_SLT:  bin_y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      default: bin_y = (a < b) ? W'(1) : '0;
    endcase
  end

  // unary operand is the top entry (b)
  always_comb begin
    case (func)
      UF_NEG:  una_y = '0 - b;
      UF_NOT:  una_y = ~b;
      UF_SHL:  una_y = {b[W-2:0], 1'b0};
      UF_SHR:  una_y = {1'b0, b[W-1:1]};
      default: una_y = b;
    endcase
  end

  assign y = is_bin ? bin_y : una_y;

endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);

  logic [W-1:0] ent [DEPTH];

  // datapath storage: no reset, written only under its own enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) ent[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a = '0;
    rd_b = '0;
    if (32'(rd_idx_a) < DEPTH) rd_a = ent[rd_idx_a];
    if (32'(rd_idx_b) < DEPTH) rd_b = ent[rd_idx_b];
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_cls,
  output logic          op_ready,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic          st_wr_en,
  output logic          st_from_mem,
  output logic [IW-1:0] st_wr_idx,
  output logic [CW-1:0] cnt,
  output logic          err
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  core_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          err_q, err_d;
  logic          fire, legal;
  op_cls_e       cls;
  logic [CW-1:0] cnt_m1, cnt_m2;

  assign cls      = op_cls_e'(op_cls);
  assign op_ready = (state_q == ST_RUN);
  assign fire     = op_valid && op_ready;
  assign cnt_m1   = cnt_q - CW'(1);
  assign cnt_m2   = cnt_q - CW'(2);

  always_comb begin
    unique case (cls)
      CLS_PUSH: legal = (cnt_q < FULL_CNT);
      CLS_BIN:  legal = (cnt_q >= CW'(2));
      default:  legal = (cnt_q != '0);
    endcase
  end

  // next-state process
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    err_d       = err_q;
    mem_rd_en   = 1'b0;
    mem_wr_en   = 1'b0;
    st_wr_en    = 1'b0;
    st_from_mem = 1'b0;
    st_wr_idx   = cnt_m1[IW-1:0];
    if (state_q == ST_FILL) begin
      st_wr_en    = 1'b1;
      st_from_mem = 1'b1;
      st_wr_idx   = cnt_q[IW-1:0];
      cnt_d       = cnt_q + CW'(1);
      state_d     = ST_RUN;
    end else if (fire) begin
      if (!legal) begin
        err_d = 1'b1;
      end else begin
        unique case (cls)
          CLS_PUSH: begin
            mem_rd_en = 1'b1;
            state_d   = ST_FILL;
          end
          CLS_POP: begin
            mem_wr_en = 1'b1;
            cnt_d     = cnt_m1;
          end
          CLS_BIN: begin
            st_wr_en  = 1'b1;
            st_wr_idx = cnt_m2[IW-1:0];
            cnt_d     = cnt_m1;
          end
          default: begin
            st_wr_en  = 1'b1;
            st_wr_idx = cnt_m1[IW-1:0];
          end
        endcase
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      err_q   <= err_d;
    end
  end

  assign cnt = cnt_q;
  assign err = err_q;

  // R7: depth never exceeds the parameter
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R9: error flag only clears through reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R8: rejected operation freezes depth, raises error, no memory strobe
  a_r8_bad_op_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !legal) |=> ($stable(cnt_q) && err_q && op_ready));
  a_r8_bad_op_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !legal) |-> (!mem_rd_en && !mem_wr_en && !st_wr_en));

  // R2: legal push stalls one cycle, then depth grows by one
  a_r2_push_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && cls == CLS_PUSH) |=> (!op_ready && $stable(cnt_q)));
  a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |=> (op_ready && cnt_q == $past(cnt_q) + CW'(1)));

  // R3 / R4: pop and binary drop the depth by one
  a_r4_bin_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && (cls == CLS_BIN || cls == CLS_POP)) |=>
      (op_ready && cnt_q == $past(cnt_q) - CW'(1)));

  // R5: unary keeps the depth
  a_r5_una_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && legal && cls == CLS_UNA) |=> (op_ready && $stable(cnt_q)));

endmodule

// File: rtl/stk_exec_core.sv
module stk_exec_core
  import stk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_cls,
  input  logic [2:0]    op_func,
  input  logic [AW-1:0] op_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic          stk_empty,
  output logic          stk_full,
  output logic          stk_err
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic          st_wr_en, st_from_mem;
  logic [IW-1:0] st_wr_idx;
  logic [CW-1:0] cnt;
  logic [CW-1:0] tos_pos, nos_pos;
  logic [W-1:0]  tos, nos, alu_y, st_wr_data;

  stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_cls     (op_cls),
    .op_ready   (op_ready),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .st_wr_en   (st_wr_en),
    .st_from_mem(st_from_mem),
    .st_wr_idx  (st_wr_idx),
    .cnt        (cnt),
    .err        (stk_err)
  );

  assign tos_pos = cnt - CW'(1);
  assign nos_pos = cnt - CW'(2);

  stk_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (st_wr_en),
    .wr_idx  (st_wr_idx),
    .wr_data (st_wr_data),
    .rd_idx_a(nos_pos[IW-1:0]),
    .rd_idx_b(tos_pos[IW-1:0]),
    .rd_a    (nos),
    .rd_b    (tos)
  );

  stk_alu #(.W(W)) u_alu (
    .is_bin(op_cls == CLS_BIN),
    .func  (op_func),
    .a     (nos),
    .b     (tos),
    .y     (alu_y)
  );

  assign st_wr_data = st_from_mem ? mem_rdata : alu_y;
  assign mem_addr   = op_addr;
  assign mem_wdata  = tos;
  assign stk_empty  = (cnt == '0);
  assign stk_full   = (cnt == CW'(DEPTH));

  // R7: the two depth flags are exclusive
  a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stk_empty && stk_full));

  // R3: memory is never read and written in the same cycle
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  // R3: a write strobe never occurs on an empty stack
  a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> !stk_empty);

endmodule

// File: tb/tb_stk_exec_core.sv
module tb_stk_exec_core;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int NVEC       = 38;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_ready;
  logic [1:0]  op_cls;
  logic [2:0]  op_func;
  logic [15:0] op_addr;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        stk_empty, stk_full, stk_err;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] bmem [256];
  logic [31:0] m_stk [DEPTH];
  int          m_cnt;
  logic        m_err;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stk_exec_core #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_cls(op_cls), .op_func(op_func), .op_addr(op_addr),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .stk_empty(stk_empty), .stk_full(stk_full), .stk_err(stk_err)
  );

  // synchronous memory responder
  always @(posedge clk) begin
    if (mem_wr_en) bmem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= bmem[mem_addr[7:0]];
  end

  // vector: {class[1:0], func[2:0], addr[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 16'd3}, {2'd0, 3'd0, 16'd4}, {2'd2, 3'd2, 16'd0}, {2'd1, 3'd0, 16'd20},
    {2'd0, 3'd0, 16'd3}, {2'd0, 3'd0, 16'd4}, {2'd2, 3'd3, 16'd0}, {2'd1, 3'd0, 16'd21},
    {2'd0, 3'd0, 16'd3}, {2'd0, 3'd0, 16'd4}, {2'd2, 3'd4, 16'd0}, {2'd1, 3'd0, 16'd22},
    {2'd0, 3'd0, 16'd3}, {2'd0, 3'd0, 16'd4}, {2'd2, 3'd5, 16'd0}, {2'd1, 3'd0, 16'd23},
    {2'd0, 3'd0, 16'd5}, {2'd0, 3'd0, 16'd1}, {2'd2, 3'd6, 16'd0}, {2'd1, 3'd0, 16'd24},
    {2'd0, 3'd0, 16'd5}, {2'd0, 3'd0, 16'd1}, {2'd2, 3'd7, 16'd0}, {2'd1, 3'd0, 16'd25},
    {2'd0, 3'd0, 16'd2}, {2'd3, 3'd0, 16'd0}, {2'd3, 3'd1, 16'd0}, {2'd1, 3'd0, 16'd26},
    {2'd0, 3'd0, 16'd5}, {2'd3, 3'd2, 16'd0}, {2'd0, 3'd0, 16'd3}, {2'd3, 3'd3, 16'd0},
    {2'd1, 3'd0, 16'd27}, {2'd1, 3'd0, 16'd28}, {2'd0, 3'd0, 16'd1}, {2'd3, 3'd6, 16'd0},
    {2'd2, 3'd1, 16'd0}, {2'd1, 3'd0, 16'd29}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_res(input logic [1:0] c, input logic [2:0] f,
                                           input logic [31:0] a, input logic [31:0] b);
    if (c == 2'd2) begin
      case (f)
        3'd0: return a + b;
        3'd1: return a - b;
        3'd2: return a & b;
        3'd3: return a | b;
        3'd4: return ~(a | b);
        3'd5: return a ^ b;
        3'd6: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: return (a < b) ? 32'd1 : 32'd0;
      endcase
    end
    case (f)
      3'd0: return 32'd0 - b;
      3'd1: return ~b;
      3'd2: return b << 1;
      3'd3: return b >> 1;
      default: return b;
    endcase
  endfunction

  task automatic check_flags(input string req);
    chk(stk_empty == (m_cnt == 0), req, 32'(stk_empty), 32'(m_cnt == 0));
    chk(stk_full == (m_cnt == DEPTH), req, 32'(stk_full), 32'(m_cnt == DEPTH));
    chk(stk_err == m_err, req, 32'(stk_err), 32'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_cnt = 0;
    m_err = 1'b0;
    #1;
    chk(stk_empty && !stk_full && !stk_err, "R1 flags", {29'd0, stk_empty, stk_full, stk_err}, 32'h4);
    chk(op_ready && !mem_rd_en && !mem_wr_en, "R1 handshake", {29'd0, op_ready, mem_rd_en, mem_wr_en}, 32'h4);
  endtask

  task automatic do_op(input logic [1:0] c, input logic [2:0] f, input logic [15:0] a);
    bit legal;
    logic [31:0] pval;
    @(negedge clk);
    op_valid = 1'b1;
    op_cls   = c;
    op_func  = f;
    op_addr  = a;
    #1;
    case (c)
      2'd0: legal = (m_cnt < DEPTH);
      2'd2: legal = (m_cnt >= 2);
      default: legal = (m_cnt > 0);
    endcase
    chk(op_ready == 1'b1, "R10 ready at offer", 32'(op_ready), 32'd1);
    if (!legal) begin
      chk(!mem_rd_en && !mem_wr_en, "R8 no strobe on rejected op",
          {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    end else if (c == 2'd0) begin
      chk(mem_rd_en && !mem_wr_en && mem_addr == a, "R2 read strobe", {15'd0, mem_rd_en, mem_addr}, {15'd0, 1'b1, a});
    end else if (c == 2'd1) begin
      chk(mem_wr_en && mem_addr == a, "R3 write strobe", {15'd0, mem_wr_en, mem_addr}, {15'd0, 1'b1, a});
      chk(mem_wdata == m_stk[m_cnt-1], "R3 R6 popped word", mem_wdata, m_stk[m_cnt-1]);
    end
    pval = bmem[a[7:0]];
    @(negedge clk);
    op_valid = 1'b0;
    if (!legal) begin
      m_err = 1'b1;
      chk(op_ready == 1'b1, "R8 one-cycle reject", 32'(op_ready), 32'd1);
    end else begin
      case (c)
        2'd0: begin
          chk(op_ready == 1'b0, "R2 push wait cycle", 32'(op_ready), 32'd0);
          @(negedge clk);
          m_stk[m_cnt] = pval;
          m_cnt++;
        end
        2'd1: m_cnt--;
        2'd2: begin
          m_stk[m_cnt-2] = ref_res(c, f, m_stk[m_cnt-2], m_stk[m_cnt-1]);
          m_cnt--;
        end
        default: m_stk[m_cnt-1] = ref_res(c, f, 32'd0, m_stk[m_cnt-1]);
      endcase
      if (c != 2'd0)
        chk(op_ready == 1'b1, "R10 single-cycle op", 32'(op_ready), 32'd1);
    end
    check_flags("R7 R9 flags after op");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 32'(i) * 32'h0001_0003;
    bmem[1] = 32'd100;
    bmem[2] = 32'd7;
    bmem[3] = 32'hF0F0_00FF;
    bmem[4] = 32'h0FF0_0F0F;
    bmem[5] = 32'h8000_0000;
    rst_n    = 1'b0;
    op_valid = 1'b0;
    op_cls   = 2'd0;
    op_func  = 3'd0;
    op_addr  = 16'd0;

    do_reset();

    // R4: A = B + C and A = B - C, values worked out by hand
    do_op(2'd0, 3'd0, 16'd1);
    do_op(2'd0, 3'd0, 16'd2);
    do_op(2'd2, 3'd0, 16'd0);
    do_op(2'd1, 3'd0, 16'd9);
    @(negedge clk);
    chk(bmem[9] == 32'd107, "R4 add result", bmem[9], 32'd107);
    do_op(2'd0, 3'd0, 16'd1);
    do_op(2'd0, 3'd0, 16'd2);
    do_op(2'd2, 3'd1, 16'd0);
    do_op(2'd1, 3'd0, 16'd10);
    @(negedge clk);
    chk(bmem[10] == 32'd93, "R4 subtract order", bmem[10], 32'd93);

    // R4 R5: table of operation sequences against the model
    for (int v = 0; v < NVEC; v++) do_op(VEC[v][20:19], VEC[v][18:16], VEC[v][15:0]);
    @(negedge clk);
    chk(bmem[24] == 32'd1, "R4 signed less-than", bmem[24], 32'd1);
    chk(bmem[25] == 32'd0, "R4 unsigned less-than", bmem[25], 32'd0);
    chk(bmem[28] == 32'd0, "R5 shift left drops msb", bmem[28], 32'd0);

    // R6 R7 R8: fill to full, reject extra push, drain in reverse order
    for (int k = 0; k < DEPTH; k++) do_op(2'd0, 3'd0, 16'(k + 1));
    chk(stk_full == 1'b1, "R7 full at DEPTH", 32'(stk_full), 32'd1);
    do_op(2'd0, 3'd0, 16'd40);
    chk(stk_err == 1'b1, "R8 push on full", 32'(stk_err), 32'd1);
    for (int k = 0; k < DEPTH; k++) do_op(2'd1, 3'd0, 16'(60 + k));
    @(negedge clk);
    chk(bmem[60] == 32'h0008_0018, "R6 last pushed pops first", bmem[60], 32'h0008_0018);
    chk(bmem[60 + DEPTH - 1] == 32'd100, "R6 first pushed pops last", bmem[60 + DEPTH - 1], 32'd100);

    // R8: pop on empty
    do_reset();
    do_op(2'd1, 3'd0, 16'd50);
    chk(stk_err == 1'b1, "R8 pop on empty", 32'(stk_err), 32'd1);

    // R8: binary with one entry leaves it intact; R9 later ops still run
    do_reset();
    do_op(2'd0, 3'd0, 16'd1);
    do_op(2'd2, 3'd0, 16'd0);
    chk(stk_err == 1'b1, "R8 binary short", 32'(stk_err), 32'd1);
    do_op(2'd3, 3'd1, 16'd0);
    do_op(2'd1, 3'd0, 16'd51);
    @(negedge clk);
    chk(bmem[51] == ~32'd100, "R9 ops run after error", bmem[51], ~32'd100);
    chk(stk_err == 1'b1, "R9 error sticky", 32'(stk_err), 32'd1);

    // R8: unary on empty
    do_reset();
    do_op(2'd3, 3'd0, 16'd0);
    chk(stk_err == 1'b1 && stk_empty == 1'b1, "R8 unary on empty",
        {30'd0, stk_err, stk_empty}, 32'd3);

    // R9: reset clears the flag
    do_reset();
    chk(stk_err == 1'b0, "R9 cleared by reset", 32'(stk_err), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule